// File: doc/BRIEF.md
# MESI Write-Hit Coherence Controller

This block holds the per-line MESI decision logic of one cache in a snoopy shared-bus system. It covers two jobs. The first is the local write hit, where the cache writes a line it already holds. The second is the snoop reaction, where another cache claims ownership of a line this cache holds. The surrounding cache supplies the line's current two-bit state with each request. The block returns the state to write back, a data-update enable, and, when needed, a bus ownership broadcast.

On a local write, the bus is used only when it must be. A line held Exclusive or Modified goes to Modified straight away and makes no bus traffic. A line held Shared first raises the ownership broadcast and holds it until the bus acknowledges. The word update and the move to Modified happen only after that acknowledge. Once any write hit completes, the writing cache holds the only valid copy. On the snoop side, a Shared copy that sees another cache's broadcast drops to Invalid. A snooped invalidate aimed at an Exclusive or Modified copy cannot occur in a correct system, so the block flags it.

Top module: `mesi_wr_hit_ctl`

## Requirements
- R1: While reset is held, loc_commit, data_we, wr_miss, bus_own, snp_done and snp_err are 0, and loc_state, snp_next, loc_line and snp_line_o are 0. The state encoding is I=00, S=01, E=10, M=11.
- R2: A write request to an Exclusive line (10), made while bus_own is low, gives loc_commit=1, data_we=1 and loc_state=M (11) one cycle later, with bus_own low.
- R3: A write request to a Modified line (11), made while bus_own is low, gives loc_commit=1, data_we=1 and loc_state=M one cycle later, with no bus action.
- R4: A write request to a Shared line (01), made while bus_own is low, raises bus_own one cycle later, with loc_commit and data_we low. bus_own stays high until bus_gnt is seen.
- R5: When bus_gnt is high in a cycle where bus_own is high, the next cycle shows loc_commit=1, data_we=1, loc_state=M and bus_own low.
- R6: A write request to an Invalid line (00) is a miss. One cycle later wr_miss=1, loc_commit=0, data_we=0 and loc_state=I.
- R7: While bus_own is high, new write requests are ignored. They produce no commit, miss or update, and the pending line index stays on loc_line.
- R8: A snooped invalidate on a Shared line gives snp_done=1, snp_next=I and snp_err=0 one cycle later.
- R9: A snooped invalidate on an Invalid line gives snp_done=1, snp_next=I and snp_err=0 one cycle later.
- R10: A snooped invalidate on an Exclusive or Modified line gives snp_done=1 and snp_err=1 one cycle later. snp_next then repeats the unchanged state.
- R11: The local and snoop paths run at the same time. A write request and a snoop in the same cycle are each handled as if alone.
- R12: loc_line carries the index of the request being reported, and snp_line_o carries the index of the last snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Local write request |
| wr_line | input | LINE_W | Line index of the write |
| wr_state | input | 2 | Current state of the written line |
| bus_gnt | input | 1 | One-cycle acknowledge of the ownership broadcast |
| snp_inv | input | 1 | Snooped ownership broadcast matches a held line |
| snp_line | input | LINE_W | Line index of the snoop |
| snp_state | input | 2 | Current state of the snooped line |
| loc_commit | output | 1 | Write hit completes; write back loc_state |
| loc_state | output | 2 | Next state for the local line |
| loc_line | output | LINE_W | Line index of the reported local result |
| data_we | output | 1 | Update the word in the data array |
| wr_miss | output | 1 | Write request was not a hit |
| bus_own | output | 1 | Ownership broadcast on the bus; also marks the block busy |
| snp_done | output | 1 | Snoop result valid |
| snp_next | output | 2 | Next state for the snooped line |
| snp_line_o | output | LINE_W | Line index of the snoop result |
| snp_err | output | 1 | Snoop hit an Exclusive or Modified line |

## Verification
Every result lands exactly one clock after the edge that samples its cause. The cause can be a write request, a snoop or a grant. bus_own alone stays high from one cycle after a Shared request until the cycle after the grant. The bench drives inputs just after each rising edge. A behavioural model updates on each rising edge, and every output is compared at the following falling edge. This puts each comparison in the first cycle its result can show, and it catches both early and late results. Directed cases run a delayed grant with requests made during the wait, and snoops on all four states, some in the same cycle as a write. A random phase with random grant timing follows.

// File: rtl/mwh_pkg.sv
package mwh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  // A write hits any line that holds valid data.
  function automatic logic wr_is_hit(input logic [1:0] st);
    return st != ST_I;
  endfunction

  // A hit needs a bus claim only when other copies may exist.
  function automatic logic wr_needs_bus(input logic [1:0] st);
    return st == ST_S;
  endfunction

  // State a snooping copy takes when another cache claims ownership.
  function automatic logic [1:0] snoop_next(input logic [1:0] st);
    return (st == ST_S) ? ST_I : st;
  endfunction

  // Exclusive or Modified copies cannot legally be snooped-invalidated.
  function automatic logic snoop_illegal(input logic [1:0] st);
    return st[1];
  endfunction
endpackage

// File: rtl/mwh_local_ctl.sv
module mwh_local_ctl
  import mwh_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [1:0]        wr_state,
  input  logic              bus_gnt,
  output logic              commit,
  output logic [1:0]        next_st,
  output logic [LINE_W-1:0] line_q,
  output logic              we,
  output logic              miss,
  output logic              own
);
  typedef enum logic {PH_IDLE, PH_WAIT} phase_e;
  phase_e phase_q;

  logic take_req;
  logic grant_seen;
  assign take_req   = wr_req && (phase_q == PH_IDLE);
  assign grant_seen = (phase_q == PH_WAIT) && bus_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      commit  <= 1'b0;
      we      <= 1'b0;
      miss    <= 1'b0;
      next_st <= ST_I;
      line_q  <= '0;
    end else begin
      commit <= 1'b0;
      we     <= 1'b0;
      miss   <= 1'b0;
      if (grant_seen) begin
        phase_q <= PH_IDLE;
        commit  <= 1'b1;
        we      <= 1'b1;
        next_st <= ST_M;
      end else if (take_req) begin
        line_q <= wr_line;
        if (!wr_is_hit(wr_state)) begin
          miss    <= 1'b1;
          next_st <= ST_I;
        end else if (wr_needs_bus(wr_state)) begin
          phase_q <= PH_WAIT;
          next_st <= ST_S;
        end else begin
          commit  <= 1'b1;
          we      <= 1'b1;
          next_st <= ST_M;
        end
      end
    end
  end

  assign own = (phase_q == PH_WAIT);
endmodule

// File: rtl/mwh_snoop_ctl.sv
module mwh_snoop_ctl
  import mwh_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_inv,
  input  logic [LINE_W-1:0] snp_line,
  input  logic [1:0]        snp_state,
  output logic              done,
  output logic [1:0]        next_st,
  output logic [LINE_W-1:0] line_q,
  output logic              err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      err     <= 1'b0;
      next_st <= ST_I;
      line_q  <= '0;
    end else begin
      done <= snp_inv;
      err  <= snp_inv && snoop_illegal(snp_state);
      if (snp_inv) begin
        next_st <= snoop_next(snp_state);
        line_q  <= snp_line;
      end
    end
  end
endmodule

// File: rtl/mesi_wr_hit_ctl.sv
module mesi_wr_hit_ctl #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [1:0]        wr_state,
  input  logic              bus_gnt,
  input  logic              snp_inv,
  input  logic [LINE_W-1:0] snp_line,
  input  logic [1:0]        snp_state,
  output logic              loc_commit,
  output logic [1:0]        loc_state,
  output logic [LINE_W-1:0] loc_line,
  output logic              data_we,
  output logic              wr_miss,
  output logic              bus_own,
  output logic              snp_done,
  output logic [1:0]        snp_next,
  output logic [LINE_W-1:0] snp_line_o,
  output logic              snp_err
);
  mwh_local_ctl #(.LINE_W(LINE_W)) u_local (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_line (wr_line),
    .wr_state(wr_state),
    .bus_gnt (bus_gnt),
    .commit  (loc_commit),
    .next_st (loc_state),
    .line_q  (loc_line),
    .we      (data_we),
    .miss    (wr_miss),
    .own     (bus_own)
  );

  mwh_snoop_ctl #(.LINE_W(LINE_W)) u_snoop (
    .clk      (clk),
    .rst_n    (rst_n),
    .snp_inv  (snp_inv),
    .snp_line (snp_line),
    .snp_state(snp_state),
    .done     (snp_done),
    .next_st  (snp_next),
    .line_q   (snp_line_o),
    .err      (snp_err)
  );
endmodule

// File: rtl/mwh_checker.sv
module mwh_checker #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic [LINE_W-1:0] wr_line,
  input logic [1:0]        wr_state,
  input logic              bus_gnt,
  input logic              snp_inv,
  input logic [LINE_W-1:0] snp_line,
  input logic [1:0]        snp_state,
  input logic              loc_commit,
  input logic [1:0]        loc_state,
  input logic [LINE_W-1:0] loc_line,
  input logic              data_we,
  input logic              wr_miss,
  input logic              bus_own,
  input logic              snp_done,
  input logic [1:0]        snp_next,
  input logic [LINE_W-1:0] snp_line_o,
  input logic              snp_err
);
  AST_SILENT_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !bus_own && wr_state == 2'b10 |=> loc_commit && data_we && loc_state == 2'b11 && !bus_own); // R2

  AST_MOD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !bus_own && wr_state == 2'b11 |=> loc_commit && loc_state == 2'b11 && !bus_own); // R3

  AST_SHARED_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !bus_own && wr_state == 2'b01 |=> bus_own && !loc_commit && !data_we); // R4

  AST_CLAIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own && !bus_gnt |=> bus_own && !loc_commit); // R4

  AST_GRANT_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own && bus_gnt |=> loc_commit && data_we && loc_state == 2'b11 && !bus_own); // R5

  AST_INVALID_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !bus_own && wr_state == 2'b00 |=> wr_miss && !loc_commit && !data_we); // R6

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |=> !wr_miss && $stable(loc_line)); // R7

  AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inv && !snp_state[1] |=> snp_done && snp_next == 2'b00 && !snp_err); // R8

  AST_SNOOP_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inv && snp_state[1] |=> snp_done && snp_err && snp_next == $past(snp_state)); // R10

  AST_SNOOP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inv |=> snp_line_o == $past(snp_line)); // R12
endmodule

bind mesi_wr_hit_ctl mwh_checker #(.LINE_W(LINE_W)) chk_i (.*);

// File: tb/mesi_wr_hit_ctl_tb_top.sv
module mesi_wr_hit_ctl_tb_top;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0;
  logic [LW-1:0] wr_line = '0;
  logic [1:0] wr_state = 2'b00;
  logic bus_gnt = 1'b0;
  logic snp_inv = 1'b0;
  logic [LW-1:0] snp_line = '0;
  logic [1:0] snp_state = 2'b00;
  logic loc_commit, data_we, wr_miss, bus_own, snp_done, snp_err;
  logic [1:0] loc_state, snp_next;
  logic [LW-1:0] loc_line, snp_line_o;

  always #10 clk = ~clk;

  mesi_wr_hit_ctl #(.LINE_W(LW)) dut_i (.*);

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int pend = -1;
  int e_commit = 0, e_we = 0, e_miss = 0, e_own = 0, e_state = 0, e_line = 0;
  int e_sdone = 0, e_snext = 0, e_sline = 0, e_serr = 0;
  string tag_w = "R1", tag_s = "R1";

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend = -1; e_commit = 0; e_we = 0; e_miss = 0; e_own = 0; e_state = 0; e_line = 0;
      e_sdone = 0; e_snext = 0; e_sline = 0; e_serr = 0; tag_w = "R1"; tag_s = "R1";
    end else begin
      e_commit = 0; e_we = 0; e_miss = 0;
      if (pend >= 0) begin
        if (bus_gnt) begin
          e_commit = 1; e_we = 1; e_state = 3; pend = -1; tag_w = "R5";
        end else tag_w = wr_req ? "R7" : "R4";
      end else if (wr_req) begin
        e_line = int'(wr_line);
        case (wr_state)
          2'b00: begin e_miss = 1; e_state = 0; tag_w = "R6"; end
          2'b01: begin pend = int'(wr_line); e_state = 1; tag_w = "R4"; end
          2'b10: begin e_commit = 1; e_we = 1; e_state = 3; tag_w = "R2"; end
          default: begin e_commit = 1; e_we = 1; e_state = 3; tag_w = "R3"; end
        endcase
      end
      e_own = (pend >= 0);
      e_sdone = snp_inv;
      e_serr = 0;
      if (snp_inv) begin
        e_sline = int'(snp_line);
        if (snp_state == 2'b01) begin e_snext = 0; tag_s = "R8"; end
        else if (snp_state == 2'b00) begin e_snext = 0; tag_s = "R9"; end
        else begin e_snext = int'(snp_state); e_serr = 1; tag_s = "R10"; end
        if (wr_req) tag_s = "R11";
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(tag_w, "loc_commit", int'(loc_commit), e_commit);
      chk(tag_w, "data_we", int'(data_we), e_we);
      chk(tag_w, "wr_miss", int'(wr_miss), e_miss);
      chk(tag_w, "bus_own", int'(bus_own), e_own);
      chk(tag_w, "loc_state", int'(loc_state), e_state);
      chk("R12", "loc_line", int'(loc_line), e_line);
      chk(tag_s, "snp_done", int'(snp_done), e_sdone);
      chk(tag_s, "snp_next", int'(snp_next), e_snext);
      chk(tag_s, "snp_err", int'(snp_err), e_serr);
      chk("R12", "snp_line_o", int'(snp_line_o), e_sline);
    end
  end

  task automatic step(bit rq, int ln, int st, bit g, bit si, int sl, int ss);
    @(posedge clk); #1;
    wr_req = rq; wr_line = LW'(ln); wr_state = 2'(st); bus_gnt = g;
    snp_inv = si; snp_line = LW'(sl); snp_state = 2'(ss);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1, 'h11, 2, 0, 0, 0, 0);    // R2 exclusive
    step(1, 'h22, 3, 0, 0, 0, 0);    // R3 modified
    step(1, 'h33, 0, 0, 0, 0, 0);    // R6 invalid miss
    step(1, 'h44, 1, 0, 0, 0, 0);    // R4 shared claim
    step(1, 'h55, 2, 0, 0, 0, 0);    // R7 ignored while waiting
    step(1, 'h66, 0, 0, 0, 0, 0);    // R7
    step(0, 0, 0, 1, 0, 0, 0);       // R5 grant
    step(0, 0, 0, 0, 1, 'h71, 1);    // R8
    step(0, 0, 0, 0, 1, 'h72, 0);    // R9
    step(0, 0, 0, 0, 1, 'h73, 2);    // R10 exclusive
    step(0, 0, 0, 0, 1, 'h74, 3);    // R10 modified
    step(1, 'h81, 3, 0, 1, 'h82, 1); // R11 concurrent
    step(1, 'h91, 1, 0, 1, 'h92, 3); // R11 with claim
    step(1, 'h93, 3, 1, 0, 0, 0);    // R5 grant with request ignored
    step(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 1) == 1, int'($urandom_range(0, 4095)), int'($urandom_range(0, 3)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           int'($urandom_range(0, 4095)), int'($urandom_range(0, 3)));
    step(0, 0, 0, 1, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #2 rst_n = 1'b0;  // R1 reset state again
    @(negedge clk); #1;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule